// File: doc/BRIEF.md
# Post-Update Load Execution Unit

This unit executes a single load whose memory address is the base register's current contents. After the load it writes an advanced base value back to that same register. A decoded operation arrives with both operand values, the base and destination register numbers, an access size, a sign-extension flag, an offset form selector and a 16-bit immediate. The unit then issues one memory read and widens the returned data to 64 bits. It presents two writebacks together: the loaded value goes to the destination register and the advanced base goes to the base register.

The offset applies only to the written-back base. The memory request always carries the unmodified base. An operation that names register 0 as its base, or names the same register as base and destination, is rejected. A rejected operation raises an illegal-operation pulse and has no other effect. No status or flag state is kept or changed.

Top module: `postinc_load_unit`

## Requirements
- R1: In reset and while idle, `op_ready` is high. An `op_valid` in a cycle where `op_ready` is high is accepted at that clock edge. `op_valid` in any other cycle is ignored. A legal operation drops `op_ready` from the next cycle until the cycle in which its writebacks appear.
- R2: The memory request carries `mem_req_addr` equal to the accepted `op_base`, with no offset added. It carries `mem_req_size` equal to the accepted size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). `mem_req_valid` rises in the cycle after acceptance and stays high with a stable address until a cycle in which `mem_req_ready` is high.
- R3: With `op_signed` low and size code 0, 1 or 2, `rt_data` holds the low 8, 16 or 32 bits of `mem_rsp_data` and every bit above them is zero.
- R4: With `op_signed` high and size code 1 or 2, every bit of `rt_data` above the loaded 16 or 32 bits equals the loaded value's most significant bit.
- R5: Size code 3 writes all 64 bits of `mem_rsp_data` unchanged. For size codes 0 and 3, `op_signed` has no effect on `rt_data`.
- R6: Form code 0: `ra_data` is `op_base` plus `op_imm` sign-extended from bit 15.
- R7: Form code 1: `ra_data` is `op_base` plus `{op_imm[13:0], 2'b00}` sign-extended from bit 13. `op_imm[15:14]` has no effect.
- R8: Form codes 2 and 3: `ra_data` is `op_base` plus `op_index`, and `op_imm` has no effect. Arithmetic wraps modulo 2^64.
- R9: When `op_ra_num` is 0 or equals `op_rt_num`, an accepted operation pulses `illegal` for exactly one cycle, in the cycle after acceptance. It makes no memory request and no writeback, and `op_ready` stays high.
- R10: `mem_rsp_valid` is taken only after the request handshake has completed. In the cycle after it is taken, `rt_we` and `ra_we` are both high for exactly one cycle, together with `rt_num`/`ra_num` of the operation. `mem_rsp_valid` at any other time is ignored.
- R11: After reset, `mem_req_valid`, `illegal`, `rt_we` and `ra_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation can be taken |
| op_base | input | 64 | Base register value |
| op_index | input | 64 | Index register value (indexed form) |
| op_ra_num | input | 5 | Base register number |
| op_rt_num | input | 5 | Destination register number |
| op_size | input | 2 | Access size code |
| op_signed | input | 1 | Sign-extend the loaded halfword/word |
| op_form | input | 2 | Offset form code |
| op_imm | input | 16 | Immediate field |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, least significant end aligned |
| rt_we | output | 1 | Destination writeback strobe |
| rt_num | output | 5 | Destination register number |
| rt_data | output | 64 | Loaded, extended value |
| ra_we | output | 1 | Base writeback strobe |
| ra_num | output | 5 | Base register number |
| ra_data | output | 64 | Advanced base value |
| illegal | output | 1 | Rejected operation pulse |

## Verification
The bench builds the unit with the defaults: a 64-bit datapath, 5-bit register numbers, a 16-bit immediate and a scale shift of 2. The full width brings the doubleword path within reach, where no extension may occur. Five-bit register numbers let random picks land on register 0 and on base-equals-destination collisions. The 16-bit immediate with shift 2 lets negative scaled offsets exercise the sign taken from bit 13 while the two ignored top bits vary. Random request back-pressure and stray response pulses test the handshake ordering in every state.

// File: rtl/pil_pkg.sv
`timescale 1ns/1ps
package pil_pkg;
  typedef enum logic [1:0] {
    FORM_DISP   = 2'd0,
    FORM_SCALED = 2'd1,
    FORM_INDEX  = 2'd2,
    FORM_INDEX2 = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  localparam int NUM_SIZES = 4;
  localparam int BASE_BITS = 8;
endpackage

// File: rtl/pil_offset.sv
`timescale 1ns/1ps
module pil_offset import pil_pkg::*; #(
  parameter int XLEN     = 64,
  parameter int IMM_W    = 16,
  parameter int SCALE_SH = 2
) (
  input  logic [1:0]       form,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  index,
  output logic [XLEN-1:0]  offset
);
  localparam int FIELD_W = IMM_W - SCALE_SH;
  localparam int PAD_W   = XLEN - IMM_W;

  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] scaled_ext;

  // plain displacement, sign from the top immediate bit
  assign disp_ext   = {{PAD_W{imm[IMM_W-1]}}, imm};
  // scaled field: low FIELD_W bits shifted up, sign from the field's top bit
  assign scaled_ext = {{PAD_W{imm[FIELD_W-1]}}, imm[FIELD_W-1:0], {SCALE_SH{1'b0}}};

  always_comb begin
    case (form_e'(form))
      FORM_DISP:   offset = disp_ext;
      FORM_SCALED: offset = scaled_ext;
      default:     offset = index;
    endcase
  end
endmodule

// File: rtl/pil_extend.sv
`timescale 1ns/1ps
module pil_extend import pil_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size,
  input  logic            sgn,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] ext
);
  logic [XLEN-1:0] lane [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
    localparam int W       = BASE_BITS << k;
    localparam bit ALG_OK  = (k == 1) || (k == 2);
    if (W >= XLEN) begin : g_full
      assign lane[k] = raw;
    end else begin : g_part
      logic fill;
      assign fill    = ALG_OK && sgn && raw[W-1];
      assign lane[k] = {{(XLEN-W){fill}}, raw[W-1:0]};
    end
  end

  assign ext = lane[size];
endmodule

// File: rtl/postinc_load_unit.sv
`timescale 1ns/1ps
module postinc_load_unit import pil_pkg::*; #(
  parameter int XLEN     = 64,
  parameter int REGW     = 5,
  parameter int IMM_W    = 16,
  parameter int SCALE_SH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [XLEN-1:0] op_base,
  input  logic [XLEN-1:0] op_index,
  input  logic [REGW-1:0] op_ra_num,
  input  logic [REGW-1:0] op_rt_num,
  input  logic [1:0]      op_size,
  input  logic            op_signed,
  input  logic [1:0]      op_form,
  input  logic [IMM_W-1:0] op_imm,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [1:0]      mem_req_size,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            rt_we,
  output logic [REGW-1:0] rt_num,
  output logic [XLEN-1:0] rt_data,
  output logic            ra_we,
  output logic [REGW-1:0] ra_num,
  output logic [XLEN-1:0] ra_data,
  output logic            illegal
);
  state_e          state_q;
  logic [XLEN-1:0] addr_q, ra_new_q, rt_data_q;
  logic [1:0]      size_q;
  logic            sgn_q;
  logic [REGW-1:0] rt_num_q, ra_num_q;
  logic            illegal_q, rt_we_q, ra_we_q;

  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] ext_data;
  logic            bad_op;
  logic            accept;

  pil_offset #(.XLEN(XLEN), .IMM_W(IMM_W), .SCALE_SH(SCALE_SH)) u_off (
    .form(op_form), .imm(op_imm), .index(op_index), .offset(offset)
  );

  pil_extend #(.XLEN(XLEN)) u_ext (
    .size(size_q), .sgn(sgn_q), .raw(mem_rsp_data), .ext(ext_data)
  );

  assign bad_op = (op_ra_num == '0) || (op_ra_num == op_rt_num);
  assign accept = op_valid && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      ra_new_q  <= '0;
      rt_data_q <= '0;
      size_q    <= '0;
      sgn_q     <= 1'b0;
      rt_num_q  <= '0;
      ra_num_q  <= '0;
      illegal_q <= 1'b0;
      rt_we_q   <= 1'b0;
      ra_we_q   <= 1'b0;
    end else begin
      illegal_q <= accept && bad_op;
      rt_we_q   <= 1'b0;
      ra_we_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept && !bad_op) begin
            addr_q   <= op_base;
            ra_new_q <= op_base + offset;
            size_q   <= op_size;
            sgn_q    <= op_signed;
            rt_num_q <= op_rt_num;
            ra_num_q <= op_ra_num;
            state_q  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rt_data_q <= ext_data;
            rt_we_q   <= 1'b1;
            ra_we_q   <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign op_ready      = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_size  = size_q;
  assign rt_we         = rt_we_q;
  assign rt_num        = rt_num_q;
  assign rt_data       = rt_data_q;
  assign ra_we         = ra_we_q;
  assign ra_num        = ra_num_q;
  assign ra_data       = ra_new_q;
  assign illegal       = illegal_q;

  // request starts with the untouched base operand of the accepted op
  assert_base_addr_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> (mem_req_addr == $past(op_base)));

  // request held steady under back-pressure
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // unit reports busy while a request is outstanding
  assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> !op_ready);

  // rejected operation: pulse only, no side effects
  assert_reject_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready && ((op_ra_num == '0) || (op_ra_num == op_rt_num)))
      |=> (illegal && !mem_req_valid && op_ready && !rt_we && !ra_we));

  // writebacks paired and only after a response while busy
  assert_wb_after_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> (ra_we && $past(mem_rsp_valid) && !$past(op_ready)));
endmodule

// File: tb/sim_postinc_load_unit.sv
`timescale 1ns/1ps
module sim_postinc_load_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [63:0] op_base = '0, op_index = '0;
  logic [4:0]  op_ra_num = '0, op_rt_num = '0;
  logic [1:0]  op_size = '0;
  logic        op_signed = 1'b0;
  logic [1:0]  op_form = '0;
  logic [15:0] op_imm = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rt_we, ra_we, illegal;
  logic [4:0]  rt_num, ra_num;
  logic [63:0] rt_data, ra_data;

  always #2 clk = ~clk;

  postinc_load_unit #(.XLEN(64), .REGW(5), .IMM_W(16), .SCALE_SH(2)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_base(op_base), .op_index(op_index), .op_ra_num(op_ra_num),
    .op_rt_num(op_rt_num), .op_size(op_size), .op_signed(op_signed),
    .op_form(op_form), .op_imm(op_imm), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rt_we(rt_we), .rt_num(rt_num),
    .rt_data(rt_data), .ra_we(ra_we), .ra_num(ra_num), .ra_data(ra_data),
    .illegal(illegal)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] ref_ext(logic [63:0] d, int sz, bit sg);
    int nbits;
    logic [63:0] mask, v;
    if (sz == 3) return d;
    nbits = 8 * (1 << sz);
    mask  = (64'd1 << nbits) - 64'd1;
    v     = d & mask;
    if (sg && (sz == 1 || sz == 2) && d[nbits-1]) v = v | ~mask;
    return v;
  endfunction

  function automatic logic [63:0] ref_off(int form, logic [15:0] imm, logic [63:0] idx);
    longint s;
    if (form == 0) begin
      s = longint'($signed(imm));
      return 64'(s);
    end else if (form == 1) begin
      s = longint'($signed({imm[13:0], 2'b00}));
      return 64'(s);
    end
    return idx;
  endfunction

  // behavioural reference: phase 0 idle, 1 requesting, 2 awaiting data
  int          m_phase = 0;
  bit          e_ill = 0, e_wb = 0;
  logic [63:0] m_addr = '0, m_ranew = '0, e_rtdata = '0;
  int          m_size = 0, m_form = 0;
  bit          m_sgn = 0;
  logic [4:0]  m_rt = '0, m_ra = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; e_ill = 0; e_wb = 0;
    end else begin
      e_ill = 0;
      e_wb  = 0;
      if (m_phase == 0) begin
        if (op_valid) begin
          if (op_ra_num == 0 || op_ra_num == op_rt_num) e_ill = 1;
          else begin
            m_addr  = op_base;
            m_size  = int'(op_size);
            m_sgn   = op_signed;
            m_form  = int'(op_form);
            m_rt    = op_rt_num;
            m_ra    = op_ra_num;
            m_ranew = op_base + ref_off(int'(op_form), op_imm, op_index);
            m_phase = 1;
          end
        end
      end else if (m_phase == 1) begin
        if (mem_req_ready) m_phase = 2;
      end else begin
        if (mem_rsp_valid) begin
          e_wb     = 1;
          e_rtdata = ref_ext(mem_rsp_data, m_size, m_sgn);
          m_phase  = 0;
        end
      end
    end
  end

  function automatic string data_tag(int sz, bit sg);
    if (sz == 3 || (sz == 0 && sg)) return "R5";
    if (sg) return "R4";
    return "R3";
  endfunction

  function automatic string form_tag(int f);
    if (f == 0) return "R6";
    if (f == 1) return "R7";
    return "R8";
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 op_ready", {63'd0, op_ready}, {63'd0, m_phase == 0});
      chk("R2 mem_req_valid", {63'd0, mem_req_valid}, {63'd0, m_phase == 1});
      if (m_phase == 1) begin
        chk("R2 mem_req_addr", mem_req_addr, m_addr);
        chk("R2 mem_req_size", {62'd0, mem_req_size}, 64'(m_size));
      end
      chk("R9 illegal", {63'd0, illegal}, {63'd0, e_ill});
      chk("R10 rt_we", {63'd0, rt_we}, {63'd0, e_wb});
      chk("R10 ra_we", {63'd0, ra_we}, {63'd0, e_wb});
      if (e_wb) begin
        chk("R10 rt_num", {59'd0, rt_num}, {59'd0, m_rt});
        chk("R10 ra_num", {59'd0, ra_num}, {59'd0, m_ra});
        chk({data_tag(m_size, m_sgn), " rt_data"}, rt_data, e_rtdata);
        chk({form_tag(m_form), " ra_data"}, ra_data, m_ranew);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic drive_op(bit v, logic [4:0] ra, logic [4:0] rt, int sz, bit sg,
                          int form, logic [15:0] imm, logic [63:0] base, logic [63:0] idx);
    op_valid  = v;
    op_ra_num = ra;
    op_rt_num = rt;
    op_size   = 2'(sz);
    op_signed = sg;
    op_form   = 2'(form);
    op_imm    = imm;
    op_base   = base;
    op_index  = idx;
  endtask

  // memory side: random back-pressure, random (also stray) response pulses
  always @(negedge clk) begin
    if (!rst) begin
      mem_req_ready = ($urandom % 3) != 0;
      mem_rsp_valid = ($urandom % 3) == 0;
      mem_rsp_data  = {$urandom, $urandom};
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    chk("R11 op_ready", {63'd0, op_ready}, 64'd1);
    chk("R11 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    chk("R11 illegal", {63'd0, illegal}, 64'd0);
    chk("R11 rt_we", {63'd0, rt_we}, 64'd0);
    chk("R11 ra_we", {63'd0, ra_we}, 64'd0);
    rst = 1'b0;
    // directed corners: every size/sign and form, rejects, wrap-around base
    for (int sz = 0; sz < 4; sz++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int f = 0; f < 4; f++) begin
          drive_op(1, 5'd3, 5'd7, sz, sg[0], f, 16'hC001, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0010);
          @(negedge clk);
          while (!op_ready) @(negedge clk);
        end
      end
    end
    drive_op(1, 5'd0, 5'd4, 0, 0, 0, 16'h0004, 64'h100, 64'h0);   // R9 base register 0
    @(negedge clk);
    drive_op(1, 5'd9, 5'd9, 1, 1, 2, 16'h0000, 64'h200, 64'h8);   // R9 base equals destination
    @(negedge clk);
    drive_op(1, 5'd5, 5'd6, 2, 1, 1, 16'h3FFF, 64'h1000, 64'h0);  // R7 scaled -4
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    drive_op(1, 5'd5, 5'd6, 2, 1, 1, 16'hBFFF, 64'h1000, 64'h0);  // R7 top bits ignored
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    // random traffic, op_valid also offered while busy (R1)
    for (int i = 0; i < 4000; i++) begin
      int pick;
      logic [4:0] rt;
      logic [4:0] ra;
      pick = $urandom % 8;
      rt = 5'($urandom);
      ra = (pick == 0) ? 5'd0 : (pick == 1) ? rt : 5'($urandom);
      drive_op(($urandom % 2) == 0, ra, rt, $urandom % 4, $urandom % 2, $urandom % 4,
               16'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
      @(negedge clk);
    end
    op_valid = 1'b0;
    repeat (20) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule